// File: doc/BRIEF.md
# Banked Serial-Port Register File

This block is the processor-side register file of a byte-oriented serial controller that follows the classic 16550 programming model. A processor reaches eight byte registers through a 3-bit offset, a byte-wide data bus and single-cycle read and write strobes. The block turns those accesses into control outputs for the transmit and receive engines, single-cycle push, pop and flush pulses, and status and interrupt readbacks built from the engines' inputs. It has no shifters, no FIFO storage and no baud counter.

Three offsets change meaning with the line control register. When its top bit is set, offsets 0 and 1 become the low and high bytes of the 16-bit baud divisor. When it holds exactly 0xBF, offset 2 becomes an extended feature register and the scratch register is hidden. The divisor is normally the 1.8432 MHz reference over 16 times the baud rate, for example 12 for 9600 baud. Line control 0x03 selects 8 data bits, one stop bit and no parity.

The transmit push is a stream output. A byte transfers when `tx_valid` and `tx_ready` are both high. `tx_valid` is held for exactly one cycle and is not held under back-pressure, so a write made while `tx_ready` is low is lost. Software avoids this by polling line status bit 5 first. On the receive side, `rx_ready` is a one-cycle pop that is raised only when `rx_valid` was high during the read, so every pop is a completed transfer.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control, interrupt enable, modem control, scratch, FIFO state, extended feature register and divisor are all 0. Offset 2 reads 0x01. With `tx_ready`=1, `tx_idle`=1, `rx_valid`=0 and no errors, offset 5 reads 0x60.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and `baud_div` presents them. A write to offset 0 in this state produces no transmit push. The divisor changes only through these writes.
- R3: While line control bit 7 is 0, a write to offset 0 raises `tx_valid` for one cycle after the write cycle, with `tx_data` equal to the byte. A read of offset 0 returns `rx_data`. It raises `rx_ready` for one cycle after the read cycle only if `rx_valid` was 1.
- R4: While line control equals 0xBF, offset 2 reads and writes the extended feature register, FIFO control is untouched, and offset 7 reads 0x00 and ignores writes. `auto_flow` is 1 when extended feature bits 7:6 are both 1.
- R5: A write to offset 2 outside the extended bank sets `fifo_enable` from bit 0, the deep-FIFO request from bit 5 and `rx_trigger` from bits 7:6. Bit 1 gives a one-cycle `rx_flush` and bit 2 a one-cycle `tx_flush`, both in the cycle after the write. Neither flush bit is stored.
- R6: Reads of offset 2 outside the extended bank return bits 7 and 6 equal to `fifo_enable`. Bit 5 is 1 only when the FIFOs are enabled and deep mode was requested.
- R7: Offset 4 reads back bits 5:0 as written and bits 7:6 as 0. Bit 0 drives `dtr`, bit 1 `rts`, bits 3:2 `out_aux` and bit 4 `loopback`. Bit 5 sets `auto_flow`.
- R8: Offset 5 reads bit 0 = `rx_valid`, bit 5 = `tx_ready` and bit 6 = `tx_idle`. Bits 1 to 4 are sticky copies of `line_err` bits 0 to 3 (overrun, parity, framing, break), cleared by reading offset 5. An error arriving in the read cycle is kept. Bit 7 is `fifo_enable` AND any sticky error.
- R9: Offset 2 bits 3:0 report the highest-priority enabled cause, with interrupt enable bits 2, 0, 1 and 3 gating them. Line error gives 0x6, received data 0x4, transmitter ready 0x2 and modem change 0x0. With no cause pending the value is 0x1. `irq` is 1 exactly when a cause is pending.
- R10: Offset 6 bits 7:4 are the sampled `modem_in` bits 3:0 (clear-to-send, data-set-ready, ring, carrier). Bits 3:0 are sticky change flags for the same lines, cleared by reading offset 6.
- R11: Offset 7 outside the extended bank stores and returns any byte. Offset 1 in the data bank returns interrupt enable bits 3:0 with bits 7:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt pending |
| tx_valid | output | 1 | Transmit push, one cycle |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit FIFO has room |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Head received byte |
| rx_ready | output | 1 | Receive pop, one cycle |
| tx_idle | input | 1 | Transmitter fully empty |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| modem_in | input | 4 | Modem lines: CTS, DSR, RI, DCD |
| line_ctrl | output | 8 | Line control register |
| baud_div | output | 16 | Baud divisor |
| fifo_enable | output | 1 | FIFOs enabled |
| fifo_deep | output | 1 | Deep FIFO mode requested |
| rx_trigger | output | 2 | Receive trigger level |
| rx_flush | output | 1 | Receive FIFO clear pulse |
| tx_flush | output | 1 | Transmit FIFO clear pulse |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out_aux | output | 2 | Auxiliary outputs |
| loopback | output | 1 | Loopback mode |
| auto_flow | output | 1 | Hardware flow control enabled |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are driven from clean registered sources and that `reg_addr` and `reg_wdata` are stable across any cycle in which a strobe is high. Because the pulse checks look back one cycle, they rely on every strobe being a single-cycle access. The stimulus drives every access as one strobe cycle followed by an idle cycle, and changes inputs only on the falling edge. It applies `line_err` and `modem_in` changes between accesses, with one deliberate exception: an error pulse placed inside a status read, to check that a new error is kept.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_IER  = 3'd1;
  localparam logic [2:0] OFF_FIFO = 3'd2;
  localparam logic [2:0] OFF_LCR  = 3'd3;
  localparam logic [2:0] OFF_MCR  = 3'd4;
  localparam logic [2:0] OFF_LSR  = 3'd5;
  localparam logic [2:0] OFF_MSR  = 3'd6;
  localparam logic [2:0] OFF_SCR  = 3'd7;

  localparam logic [7:0] EXT_KEY = 8'hBF;
  localparam int ERR_W   = 4;
  localparam int MODEM_W = 4;
  localparam int IER_W   = 4;
  localparam int MCR_W   = 6;

  typedef enum logic [1:0] {
    BANK_DATA = 2'd0,
    BANK_DIV  = 2'd1,
    BANK_EXT  = 2'd2
  } bank_e;

  typedef struct packed {
    logic wr_thr;
    logic rd_rbr;
    logic wr_dll;
    logic wr_dlm;
    logic wr_ier;
    logic wr_fcr;
    logic wr_efr;
    logic wr_lcr;
    logic wr_mcr;
    logic wr_scr;
    logic rd_lsr;
    logic rd_msr;
  } acc_t;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regbank_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] lcr,
  output bank_e      bank,
  output acc_t       acc
);
  // extended bank overlays the divisor bank: key value has bit 7 set
  always_comb begin
    if (lcr == EXT_KEY)   bank = BANK_EXT;
    else if (lcr[7])      bank = BANK_DIV;
    else                  bank = BANK_DATA;
  end

  always_comb begin
    acc = '0;
    unique case (addr)
      OFF_DATA: begin
        if (bank == BANK_DATA) begin
          acc.wr_thr = wr_en;
          acc.rd_rbr = rd_en;
        end else begin
          acc.wr_dll = wr_en;
        end
      end
      OFF_IER: begin
        if (bank == BANK_DATA) acc.wr_ier = wr_en;
        else                   acc.wr_dlm = wr_en;
      end
      OFF_FIFO: begin
        if (bank == BANK_EXT) acc.wr_efr = wr_en;
        else                  acc.wr_fcr = wr_en;
      end
      OFF_LCR: acc.wr_lcr = wr_en;
      OFF_MCR: acc.wr_mcr = wr_en;
      OFF_LSR: acc.rd_lsr = rd_en;
      OFF_MSR: acc.rd_msr = rd_en;
      OFF_SCR: acc.wr_scr = wr_en && (bank != BANK_EXT);
      default: acc = '0;
    endcase
  end
endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  output logic [DATA_W-1:0] lcr,
  output logic [IER_W-1:0]  ier,
  output logic [MCR_W-1:0]  mcr,
  output logic [DATA_W-1:0] scr,
  output logic [DATA_W-1:0] efr,
  output logic [DIV_W-1:0]  divisor,
  output logic              fifo_en,
  output logic              fifo_deep,
  output logic [1:0]        rx_trig,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_ready
);
  // stored configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr       <= '0;
      ier       <= '0;
      mcr       <= '0;
      scr       <= '0;
      efr       <= '0;
      divisor   <= '0;
      fifo_en   <= 1'b0;
      fifo_deep <= 1'b0;
      rx_trig   <= '0;
    end else begin
      if (acc.wr_lcr) lcr <= wdata;
      if (acc.wr_ier) ier <= wdata[IER_W-1:0];
      if (acc.wr_mcr) mcr <= wdata[MCR_W-1:0];
      if (acc.wr_scr) scr <= wdata;
      if (acc.wr_efr) efr <= wdata;
      if (acc.wr_dll) divisor[DATA_W-1:0]     <= wdata;
      if (acc.wr_dlm) divisor[DIV_W-1:DATA_W] <= wdata;
      if (acc.wr_fcr) begin
        fifo_en   <= wdata[0];
        fifo_deep <= wdata[5];
        rx_trig   <= wdata[7:6];
      end
    end
  end

  // single-cycle strobes, one cycle after the access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      rx_ready <= 1'b0;
    end else begin
      rx_flush <= acc.wr_fcr && wdata[1];
      tx_flush <= acc.wr_fcr && wdata[2];
      tx_valid <= acc.wr_thr;
      rx_ready <= acc.rd_rbr && rx_valid;
      if (acc.wr_thr) tx_data <= wdata;
    end
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_lsr,
  input  logic               rd_msr,
  input  logic [ERR_W-1:0]   err_in,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               rx_valid,
  input  logic               tx_ready,
  input  logic               tx_idle,
  input  logic               fifo_en,
  input  logic               fifo_deep,
  input  logic [IER_W-1:0]   ier,
  output logic [7:0]         lsr,
  output logic [7:0]         msr,
  output logic [7:0]         iir,
  output logic               pending
);
  logic [ERR_W-1:0]   err_q;
  logic [MODEM_W-1:0] lines_q;
  logic [MODEM_W-1:0] delta_q;
  logic [2:0]         cause;

  // sticky errors: a new error wins over the read clear
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (rd_lsr ? '0 : err_q) | err_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= modem_in;
  end

  for (genvar i = 0; i < MODEM_W; i++) begin : g_delta
    always_ff @(posedge clk) begin
      if (!rst_n)                        delta_q[i] <= 1'b0;
      else if (modem_in[i] != lines_q[i]) delta_q[i] <= 1'b1;
      else if (rd_msr)                   delta_q[i] <= 1'b0;
    end
  end

  always_comb begin
    lsr = {fifo_en && (|err_q), tx_idle, tx_ready, err_q, rx_valid};
    msr = {lines_q, delta_q};
  end

  // priority: line error, data ready, transmitter ready, modem change
  always_comb begin
    pending = 1'b1;
    if (ier[2] && (|err_q))        cause = 3'b011;
    else if (ier[0] && rx_valid)   cause = 3'b010;
    else if (ier[1] && tx_ready)   cause = 3'b001;
    else if (ier[3] && (|delta_q)) cause = 3'b000;
    else begin
      cause   = 3'b000;
      pending = 1'b0;
    end
    iir = {fifo_en, fifo_en, fifo_en && fifo_deep, 1'b0, cause, !pending};
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               tx_valid,
  output logic [DATA_W-1:0]  tx_data,
  input  logic               tx_ready,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               rx_ready,
  input  logic               tx_idle,
  input  logic [ERR_W-1:0]   line_err,
  input  logic [MODEM_W-1:0] modem_in,
  output logic [DATA_W-1:0]  line_ctrl,
  output logic [DIV_W-1:0]   baud_div,
  output logic               fifo_enable,
  output logic               fifo_deep,
  output logic [1:0]         rx_trigger,
  output logic               rx_flush,
  output logic               tx_flush,
  output logic               dtr,
  output logic               rts,
  output logic [1:0]         out_aux,
  output logic               loopback,
  output logic               auto_flow
);
  bank_e             bank;
  acc_t              acc;
  logic [IER_W-1:0]  ier;
  logic [MCR_W-1:0]  mcr;
  logic [DATA_W-1:0] scr;
  logic [DATA_W-1:0] efr;
  logic [7:0]        lsr;
  logic [7:0]        msr;
  logic [7:0]        iir;

  uart_reg_decode u_decode (
    .addr  (reg_addr),
    .wr_en (reg_wr),
    .rd_en (reg_rd),
    .lcr   (line_ctrl),
    .bank  (bank),
    .acc   (acc)
  );

  uart_reg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wdata     (reg_wdata),
    .rx_valid  (rx_valid),
    .lcr       (line_ctrl),
    .ier       (ier),
    .mcr       (mcr),
    .scr       (scr),
    .efr       (efr),
    .divisor   (baud_div),
    .fifo_en   (fifo_enable),
    .fifo_deep (fifo_deep),
    .rx_trig   (rx_trigger),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_ready  (rx_ready)
  );

  uart_line_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lsr    (acc.rd_lsr),
    .rd_msr    (acc.rd_msr),
    .err_in    (line_err),
    .modem_in  (modem_in),
    .rx_valid  (rx_valid),
    .tx_ready  (tx_ready),
    .tx_idle   (tx_idle),
    .fifo_en   (fifo_enable),
    .fifo_deep (fifo_deep),
    .ier       (ier),
    .lsr       (lsr),
    .msr       (msr),
    .iir       (iir),
    .pending   (irq)
  );

  always_comb begin
    dtr       = mcr[0];
    rts       = mcr[1];
    out_aux   = mcr[3:2];
    loopback  = mcr[4];
    auto_flow = mcr[5] || (efr[7:6] == 2'b11);
  end

  // read mux, banked on the line control value
  always_comb begin
    unique case (reg_addr)
      OFF_DATA: reg_rdata = (bank == BANK_DATA) ? rx_data : baud_div[DATA_W-1:0];
      OFF_IER:  reg_rdata = (bank == BANK_DATA) ? {{(DATA_W-IER_W){1'b0}}, ier}
                                                : baud_div[DIV_W-1:DATA_W];
      OFF_FIFO: reg_rdata = (bank == BANK_EXT) ? efr : DATA_W'(iir);
      OFF_LCR:  reg_rdata = line_ctrl;
      OFF_MCR:  reg_rdata = {{(DATA_W-MCR_W){1'b0}}, mcr};
      OFF_LSR:  reg_rdata = DATA_W'(lsr);
      OFF_MSR:  reg_rdata = DATA_W'(msr);
      OFF_SCR:  reg_rdata = (bank == BANK_EXT) ? '0 : scr;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        irq,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [7:0]  line_ctrl,
  input logic [15:0] baud_div,
  input logic        fifo_enable,
  input logic        rx_flush,
  input logic        dtr
);
  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && (reg_addr <= 3'd1) && line_ctrl[7]) |-> $stable(baud_div));

  p_tx_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(reg_wr && reg_addr == 3'd0 && !line_ctrl[7])
                  && tx_data == $past(reg_wdata)));

  p_pop_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> $past(reg_rd && reg_addr == 3'd0 && !line_ctrl[7] && rx_valid));

  p_scr_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ctrl == 8'hBF && reg_addr == 3'd7) |-> reg_rdata == 8'h00);

  p_flush_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> $past(reg_wr && reg_addr == 3'd2 && reg_wdata[1] && line_ctrl != 8'hBF));

  p_iir_fifo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2 && line_ctrl != 8'hBF) |-> reg_rdata[7:6] == {2{fifo_enable}});

  p_dtr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == 3'd4) |-> $stable(dtr));

  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2 && line_ctrl != 8'hBF) |-> irq != reg_rdata[0]);
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .tx_valid    (tx_valid),
  .tx_data     (tx_data),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .line_ctrl   (line_ctrl),
  .baud_div    (baud_div),
  .fifo_enable (fifo_enable),
  .rx_flush    (rx_flush),
  .dtr         (dtr)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq, tx_valid, rx_ready, fifo_enable, fifo_deep;
  logic [7:0]  tx_data, line_ctrl;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_idle = 1'b1;
  logic [3:0]  line_err = '0;
  logic [3:0]  modem_in = '0;
  logic [15:0] baud_div;
  logic [1:0]  rx_trigger, out_aux;
  logic        rx_flush, tx_flush, dtr, rts, loopback, auto_flow;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_regbank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_idle(tx_idle), .line_err(line_err), .modem_in(modem_in),
    .line_ctrl(line_ctrl), .baud_div(baud_div), .fifo_enable(fifo_enable),
    .fifo_deep(fifo_deep), .rx_trigger(rx_trigger), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .dtr(dtr), .rts(rts), .out_aux(out_aux),
    .loopback(loopback), .auto_flow(auto_flow)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd2, v); check("R1 iir", v, 8'h01);
    rd(3'd5, v); check("R1 lsr", v, 8'h60);
    check("R1 div", baud_div, 16'h0000);
    check("R1 lcr", line_ctrl, 8'h00);
    check("R1 ctl", {dtr, rts, loopback, auto_flow, fifo_enable}, 5'b0);
  endtask

  task automatic t_divisor;
    logic [7:0] v;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h0C);
    check("R2 no push under divisor bank", tx_valid, 1'b0);
    wr(3'd1, 8'h5A);
    rd(3'd1, v); check("R2 high byte", v, 8'h5A);
    rd(3'd0, v); check("R2 low byte", v, 8'h0C);
    check("R2 baud_div", baud_div, 16'h5A0C);
    wr(3'd3, 8'h03);
    rd(3'd1, v); check("R2 offset1 back to enable reg", v, 8'h00);
    check("R2 divisor kept", baud_div, 16'h5A0C);
  endtask

  task automatic t_data;
    logic [7:0] v;
    wr(3'd0, 8'h41);
    check("R3 push", {tx_valid, tx_data}, {1'b1, 8'h41});
    @(negedge clk);
    check("R3 push one cycle", tx_valid, 1'b0);
    rx_valid = 1'b1; rx_data = 8'h9C;
    rd(3'd0, v);
    check("R3 rx byte", v, 8'h9C);
    check("R3 pop", rx_ready, 1'b1);
    @(negedge clk);
    check("R3 pop one cycle", rx_ready, 1'b0);
    rx_valid = 1'b0;
    rd(3'd0, v);
    check("R3 no pop when empty", rx_ready, 1'b0);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    wr(3'd7, 8'h5A);
    wr(3'd3, 8'hBF);
    rd(3'd7, v); check("R4 scratch hidden", v, 8'h00);
    wr(3'd7, 8'h11);
    wr(3'd2, 8'hC0);
    rd(3'd2, v); check("R4 ext reg", v, 8'hC0);
    check("R4 auto_flow", auto_flow, 1'b1);
    check("R4 fifo untouched", fifo_enable, 1'b0);
    wr(3'd3, 8'h03);
    rd(3'd7, v); check("R4 scratch write ignored", v, 8'h5A);
    rd(3'd2, v); check("R4 offset2 back to id", v, 8'h01);
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'h40);
    check("R4 one bit no flow", auto_flow, 1'b0);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_fifo;
    logic [7:0] v;
    wr(3'd2, 8'h07);
    check("R5 both flush", {rx_flush, tx_flush}, 2'b11);
    @(negedge clk);
    check("R5 flush one cycle", {rx_flush, tx_flush}, 2'b00);
    check("R5 enable", fifo_enable, 1'b1);
    rd(3'd2, v); check("R6 fifo bits", v, 8'hC1);
    wr(3'd2, 8'h23);
    check("R5 rx flush only", {rx_flush, tx_flush}, 2'b10);
    rd(3'd2, v); check("R6 deep bit", v, 8'hE1);
    wr(3'd2, 8'hC1);
    check("R5 trigger", rx_trigger, 2'b11);
    check("R5 no flush stored", {rx_flush, tx_flush}, 2'b00);
    wr(3'd2, 8'h20);
    rd(3'd2, v); check("R6 deep needs enable", v, 8'h01);
  endtask

  task automatic t_mcr;
    logic [7:0] v;
    wr(3'd4, 8'h23);
    rd(3'd4, v); check("R7 readback", v, 8'h23);
    check("R7 pins", {dtr, rts, auto_flow}, 3'b111);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); check("R7 top bits zero", v, 8'h3F);
    check("R7 aux loop", {out_aux, loopback}, 3'b111);
    wr(3'd4, 8'h02);
    check("R7 pins2", {dtr, rts, auto_flow}, 3'b010);
  endtask

  task automatic t_lsr;
    logic [7:0] v;
    @(negedge clk); line_err = 4'b0101;
    @(negedge clk); line_err = 4'b0000;
    rd(3'd5, v); check("R8 sticky", v, 8'h6A);
    rd(3'd5, v); check("R8 cleared", v, 8'h60);
    wr(3'd2, 8'h01);
    @(negedge clk);
    reg_addr = 3'd5; reg_rd = 1'b1; line_err = 4'b0010;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; line_err = 4'b0000;
    check("R8 read during error", v, 8'h60);
    rd(3'd5, v); check("R8 error kept, bit7", v, 8'hE4);
    rx_valid = 1'b1; tx_ready = 1'b0; tx_idle = 1'b0;
    rd(3'd5, v); check("R8 live bits", v, 8'h01);
    rx_valid = 1'b0; tx_ready = 1'b1; tx_idle = 1'b1;
    wr(3'd2, 8'h00);
  endtask

  task automatic t_iir;
    logic [7:0] v;
    wr(3'd1, 8'h02);
    rd(3'd2, v); check("R9 tx ready cause", v, 8'h02);
    check("R9 irq", irq, 1'b1);
    rx_valid = 1'b1;
    wr(3'd1, 8'h03);
    rd(3'd2, v); check("R9 rx over tx", v, 8'h04);
    @(negedge clk); line_err = 4'b1000;
    @(negedge clk); line_err = 4'b0000;
    wr(3'd1, 8'h07);
    rd(3'd2, v); check("R9 line over rx", v, 8'h06);
    rd(3'd5, v);
    rd(3'd2, v); check("R9 after clear", v, 8'h04);
    rx_valid = 1'b0;
    wr(3'd1, 8'hFF);
    rd(3'd1, v); check("R11 enable width", v, 8'h0F);
    wr(3'd1, 8'h08);
    rd(3'd2, v); check("R9 none", v, 8'h01);
    check("R9 irq low", irq, 1'b0);
  endtask

  task automatic t_msr;
    logic [7:0] v;
    @(negedge clk); modem_in = 4'b0001;
    @(negedge clk);
    rd(3'd2, v); check("R9 modem cause", v, 8'h00);
    rd(3'd6, v); check("R10 line+delta", v, 8'h11);
    rd(3'd6, v); check("R10 delta cleared", v, 8'h10);
    rd(3'd2, v); check("R10 cause gone", v, 8'h01);
    @(negedge clk); modem_in = 4'b1000;
    @(negedge clk);
    rd(3'd6, v); check("R10 two deltas", v, 8'h89);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_scr;
    logic [7:0] v;
    wr(3'd7, 8'hA5);
    rd(3'd7, v); check("R11 scratch", v, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divisor();
    t_data();
    t_ext();
    t_fifo();
    t_mcr();
    t_lsr();
    t_iir();
    t_msr();
    t_scr();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule